// File: doc/BRIEF.md
# Programmable Line-Combining Pixel Formatter

This block sits between a pixel source that delivers each output line as several shorter divided lines and a line memory that holds the merged result. Consecutive valid divided lines are collected into groups. For every accepted pixel the block produces a write address into the line memory, so that pixels from the lines of one group are interleaved into a single output line. A horizontal-sync strobe is emitted once per merged line.

Addresses come from a bank of address pointers. Each pointer is loaded with its own initial value at the start of every group and advances by a shared step after it is used. The line's position inside its group selects a program set. Each set is a short list of entries that is walked pixel by pixel. An entry names the pointer to use, says whether the pixel is written at all, and says whether the pointer advances afterwards. When either the enable bit or the merge bit is clear, the block passes pixels straight through: every pixel is written at its index within the line.

The pixel input and the memory write port are valid/ready streams with back-pressure passed straight through. The input is ready exactly when the memory port is ready. No counter, pointer or program index moves unless a pixel is actually transferred, and a source that is stalled must hold its pixel and its valid. The sync strobes and the configuration are plain level/pulse pins.

Top module: `fmt_line_combiner`

## Requirements
- R1: Merging is active only when `cfg_en` and `cfg_combine` are both 1. Otherwise every input pixel is written (`wr_valid` follows `in_valid`), `wr_addr` is the pixel's index counted from 0 after the last `hs_in`, and `hs_out` pulses once for every `hs_in`.
- R2: While merging, the number of divided lines per group is `cfg_lines_m1`+1. `hs_out` pulses once per group, in the cycle after the `hs_in` that opens the group's first valid line, and for no other `hs_in`.
- R3: While merging, only pixels with index i (0 = first pixel after `hs_in`) such that `cfg_hstart` <= i <= `cfg_hstart`+`cfg_hlen_m1` can be written. Pixels outside that window are accepted but not written.
- R4: While merging, divided lines are numbered from 0 at the first `hs_in` after `vs_in`. Only lines numbered `cfg_vstart` through `cfg_vstart`+`cfg_vlen_m1` produce writes or count toward groups.
- R5: At the `hs_in` that opens a group, pointer k is loaded from `cfg_ptr_init[k*13 +: 13]`. When a pointer advances it grows by `cfg_step_m1`+1, modulo 2^13. With three lines of 768 pixels, pointer pairs 4/5, 2/3 and 0/1 for the three lines, initial values 0..5 and a step of 6, each group writes every address 0..2303 exactly once.
- R6: The line at position g of a group uses program set g (sets 0..2; a fourth line reuses set 2). Set g has `cfg_ent_cnt_m1[g*2 +: 2]`+1 entries. The entry index is 0 at each `hs_in` and steps cyclically on every transferred pixel inside both windows.
- R7: Entry e of set g is bit g*4+e of `cfg_ent_valid`. A pixel whose entry has that bit clear is not written, and its pointer does not advance.
- R8: The pointer of entry g*4+e is `cfg_ent_sel[(g*4+e)*3 +: 3]`. After a written pixel it advances only if bit g*4+e of `cfg_ent_upd` is 1; otherwise it keeps its value for the next use.
- R9: `in_ready` equals `wr_ready`, and `wr_data` equals `in_data`. While `wr_ready` is 0, a held pixel keeps the same `wr_valid` and `wr_addr`, and no state advances.
- R10: During and right after reset, `hs_out` and `wr_valid` are 0 while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Formatter enable |
| cfg_combine | input | 1 | Merge divided lines |
| cfg_lines_m1 | input | 2 | Lines per group minus one |
| cfg_hstart | input | 13 | First valid pixel of a divided line |
| cfg_hlen_m1 | input | 13 | Valid pixels per divided line minus one |
| cfg_vstart | input | 13 | First valid divided line |
| cfg_vlen_m1 | input | 15 | Valid divided lines minus one |
| cfg_step_m1 | input | 4 | Pointer step minus one |
| cfg_ptr_init | input | 78 | Six 13-bit initial pointer values |
| cfg_ent_cnt_m1 | input | 6 | Entries per set minus one, 2 bits per set |
| cfg_ent_valid | input | 12 | Entry write flags, 4 per set |
| cfg_ent_sel | input | 36 | Entry pointer selects, 3 bits each |
| cfg_ent_upd | input | 12 | Entry pointer-advance flags |
| hs_in | input | 1 | Divided-line start strobe |
| vs_in | input | 1 | Frame start strobe |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | 12 | Input pixel value |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts write |
| wr_addr | output | 13 | Memory write address |
| wr_data | output | 12 | Memory write value |
| hs_out | output | 1 | Merged-line start strobe |

## Verification
The assertions assume that `hs_in` and `vs_in` are single-cycle pulses that never coincide with `in_valid`. They also assume that a stalled source holds its pixel and its valid until the transfer, and that the configuration stays constant within a frame. The stimulus drives sync strobes only between pixels, and changes configuration only before a `vs_in`. During back-pressure it keeps `in_valid` and `in_data` steady while `wr_ready` is low.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef enum logic {FMT_PASS = 1'b0, FMT_MERGE = 1'b1} fmt_mode_e;

  function automatic fmt_mode_e fmt_mode(input logic en, input logic combine);
    return (en && combine) ? FMT_MERGE : FMT_PASS;
  endfunction
endpackage

// File: rtl/fmt_timing.sv
module fmt_timing #(
  parameter int HW = 13,
  parameter int VW = 15,
  parameter int GW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          pix_fire,
  input  logic          merge,
  input  logic [GW-1:0] lines_m1,
  input  logic [HW-1:0] hstart,
  input  logic [HW-1:0] hlen_m1,
  input  logic [HW-1:0] vstart,
  input  logic [VW-1:0] vlen_m1,
  output logic [HW-1:0] hcnt,
  output logic [VW:0]   vcnt,
  output logic          line_seen,
  output logic          hwin,
  output logic          vwin,
  output logic [GW-1:0] grp,
  output logic          grp_load,
  output logic          hs_out
);
  localparam int VXW = VW + 1;

  logic          grp_first;
  logic [VXW-1:0] v_next, v_lo, v_hi;
  logic          next_in_win;

  assign v_lo   = VXW'(vstart);
  assign v_hi   = VXW'(vstart) + VXW'(vlen_m1);
  assign v_next = !line_seen ? '0 : ((vcnt == '1) ? vcnt : vcnt + 1'b1);
  assign next_in_win = (v_next >= v_lo) && (v_next <= v_hi);

  assign vwin = line_seen && (vcnt >= v_lo) && (vcnt <= v_hi);
  assign hwin = (hcnt >= hstart) && ((hcnt - hstart) <= hlen_m1);

  assign grp_load = hs_in && merge && next_in_win && (grp_first || grp == lines_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt      <= '0;
      vcnt      <= '0;
      line_seen <= 1'b0;
      grp       <= '0;
      grp_first <= 1'b1;
      hs_out    <= 1'b0;
    end else begin
      hs_out <= hs_in && (!merge || grp_load);
      if (vs_in) begin
        line_seen <= 1'b0;
        vcnt      <= '0;
        hcnt      <= '0;
        grp       <= '0;
        grp_first <= 1'b1;
      end else if (hs_in) begin
        line_seen <= 1'b1;
        vcnt      <= v_next;
        hcnt      <= '0;
        if (merge && next_in_win) begin
          if (grp_first || grp == lines_m1) begin
            grp       <= '0;
            grp_first <= 1'b0;
          end else begin
            grp <= grp + 1'b1;
          end
        end
      end else if (pix_fire && hcnt != '1) begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fmt_prog.sv
module fmt_prog #(
  parameter int SETS = 3,
  parameter int ENTS = 4,
  parameter int PTRS = 6,
  parameter int GW   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               hs_in,
  input  logic                               step_en,
  input  logic [GW-1:0]                      grp,
  input  logic [SETS*$clog2(ENTS)-1:0]       cnt_flat,
  input  logic [SETS*ENTS-1:0]               valid_flat,
  input  logic [SETS*ENTS*$clog2(PTRS)-1:0]  sel_flat,
  input  logic [SETS*ENTS-1:0]               upd_flat,
  output logic [$clog2(ENTS)-1:0]            ent_idx,
  output logic [$clog2(ENTS)-1:0]            cur_cnt,
  output logic                               ent_valid,
  output logic [$clog2(PTRS)-1:0]            ent_sel,
  output logic                               ent_upd
);
  localparam int EW  = $clog2(ENTS);
  localparam int PSW = $clog2(PTRS);

  int set_idx;
  int flat;

  always_comb begin
    set_idx   = (int'(grp) >= SETS) ? SETS - 1 : int'(grp);
    flat      = set_idx * ENTS + int'(ent_idx);
    cur_cnt   = cnt_flat[set_idx*EW +: EW];
    ent_valid = valid_flat[flat];
    ent_upd   = upd_flat[flat];
    ent_sel   = sel_flat[flat*PSW +: PSW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hs_in) begin
      ent_idx <= '0;
    end else if (step_en) begin
      ent_idx <= (ent_idx >= cur_cnt) ? '0 : ent_idx + 1'b1;
    end
  end
endmodule

// File: rtl/fmt_ptr_bank.sv
module fmt_ptr_bank #(
  parameter int PTRS = 6,
  parameter int AW   = 13,
  parameter int STW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [PTRS*AW-1:0]       init_flat,
  input  logic                     adv,
  input  logic [$clog2(PTRS)-1:0]  sel,
  input  logic [STW-1:0]           step_m1,
  output logic [AW-1:0]            addr
);
  logic [AW-1:0] ptr [PTRS];
  logic [AW-1:0] step;

  assign step = AW'(step_m1) + 1'b1;

  for (genvar k = 0; k < PTRS; k++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr[k] <= '0;
      end else if (load) begin
        ptr[k] <= init_flat[k*AW +: AW];
      end else if (adv && int'(sel) == k) begin
        ptr[k] <= ptr[k] + step;
      end
    end
  end

  always_comb begin
    addr = '0;
    for (int k = 0; k < PTRS; k++) begin
      if (int'(sel) == k) addr = ptr[k];
    end
  end
endmodule

// File: rtl/fmt_line_combiner.sv
module fmt_line_combiner #(
  parameter int HW   = 13,
  parameter int VW   = 15,
  parameter int AW   = 13,
  parameter int DW   = 12,
  parameter int GW   = 2,
  parameter int STW  = 4,
  parameter int PTRS = 6,
  parameter int SETS = 3,
  parameter int ENTS = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_en,
  input  logic                               cfg_combine,
  input  logic [GW-1:0]                      cfg_lines_m1,
  input  logic [HW-1:0]                      cfg_hstart,
  input  logic [HW-1:0]                      cfg_hlen_m1,
  input  logic [HW-1:0]                      cfg_vstart,
  input  logic [VW-1:0]                      cfg_vlen_m1,
  input  logic [STW-1:0]                     cfg_step_m1,
  input  logic [PTRS*AW-1:0]                 cfg_ptr_init,
  input  logic [SETS*$clog2(ENTS)-1:0]       cfg_ent_cnt_m1,
  input  logic [SETS*ENTS-1:0]               cfg_ent_valid,
  input  logic [SETS*ENTS*$clog2(PTRS)-1:0]  cfg_ent_sel,
  input  logic [SETS*ENTS-1:0]               cfg_ent_upd,
  input  logic                               hs_in,
  input  logic                               vs_in,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [DW-1:0]                      in_data,
  output logic                               wr_valid,
  input  logic                               wr_ready,
  output logic [AW-1:0]                      wr_addr,
  output logic [DW-1:0]                      wr_data,
  output logic                               hs_out
);
  import fmt_pkg::*;

  localparam int EW  = $clog2(ENTS);
  localparam int PSW = $clog2(PTRS);

  fmt_mode_e        mode;
  logic             active;
  logic             fire;
  logic             in_win;
  logic [HW-1:0]    hcnt;
  logic [VW:0]      vcnt;
  logic             line_seen;
  logic             hwin, vwin;
  logic [GW-1:0]    grp;
  logic             grp_load;
  logic [EW-1:0]    ent_idx, cur_cnt;
  logic             ent_valid, ent_upd;
  logic [PSW-1:0]   ent_sel;
  logic [AW-1:0]    ptr_addr;

  assign mode     = fmt_mode(cfg_en, cfg_combine);
  assign active   = (mode == FMT_MERGE);
  assign in_ready = wr_ready;
  assign fire     = in_valid && wr_ready;
  assign in_win   = hwin && vwin;

  fmt_timing #(.HW(HW), .VW(VW), .GW(GW)) u_timing (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in),
    .pix_fire(fire), .merge(active), .lines_m1(cfg_lines_m1),
    .hstart(cfg_hstart), .hlen_m1(cfg_hlen_m1),
    .vstart(cfg_vstart), .vlen_m1(cfg_vlen_m1),
    .hcnt(hcnt), .vcnt(vcnt), .line_seen(line_seen),
    .hwin(hwin), .vwin(vwin), .grp(grp), .grp_load(grp_load),
    .hs_out(hs_out)
  );

  fmt_prog #(.SETS(SETS), .ENTS(ENTS), .PTRS(PTRS), .GW(GW)) u_prog (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in),
    .step_en(active && fire && in_win), .grp(grp),
    .cnt_flat(cfg_ent_cnt_m1), .valid_flat(cfg_ent_valid),
    .sel_flat(cfg_ent_sel), .upd_flat(cfg_ent_upd),
    .ent_idx(ent_idx), .cur_cnt(cur_cnt), .ent_valid(ent_valid),
    .ent_sel(ent_sel), .ent_upd(ent_upd)
  );

  fmt_ptr_bank #(.PTRS(PTRS), .AW(AW), .STW(STW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .load(grp_load), .init_flat(cfg_ptr_init),
    .adv(active && fire && in_win && ent_valid && ent_upd),
    .sel(ent_sel), .step_m1(cfg_step_m1), .addr(ptr_addr)
  );

  assign wr_valid = active ? (in_valid && in_win && ent_valid) : in_valid;
  assign wr_addr  = active ? ptr_addr : AW'(hcnt);
  assign wr_data  = in_data;
endmodule

// File: rtl/fmt_line_combiner_chk.sv
module fmt_line_combiner_chk #(
  parameter int HW = 13,
  parameter int VW = 15,
  parameter int AW = 13,
  parameter int EW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          hs_in,
  input logic          vs_in,
  input logic          in_valid,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic          hs_out,
  input logic [HW-1:0] hcnt,
  input logic [VW:0]   vcnt,
  input logic          line_seen,
  input logic [HW-1:0] cfg_hstart,
  input logic [HW-1:0] cfg_hlen_m1,
  input logic [HW-1:0] cfg_vstart,
  input logic [EW-1:0] ent_idx,
  input logic [EW-1:0] cur_cnt
);
  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && in_valid) |-> (wr_valid && wr_addr == AW'(hcnt)));

  // R2
  hs_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_out |-> $past(hs_in));

  // R3
  hwin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_valid) |->
      (hcnt >= cfg_hstart && (HW+1)'(hcnt) <= (HW+1)'(cfg_hstart) + (HW+1)'(cfg_hlen_m1)));

  // R4
  vwin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_valid) |-> (line_seen && vcnt >= (VW+1)'(cfg_vstart)));

  // R6
  ent_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (ent_idx <= cur_cnt));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !hs_in && !vs_in) |=>
      (!in_valid || (wr_valid && $stable(wr_addr))));
endmodule

bind fmt_line_combiner fmt_line_combiner_chk #(.HW(HW), .VW(VW), .AW(AW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .hs_in(hs_in), .vs_in(vs_in),
  .in_valid(in_valid), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .hs_out(hs_out), .hcnt(hcnt), .vcnt(vcnt),
  .line_seen(line_seen), .cfg_hstart(cfg_hstart), .cfg_hlen_m1(cfg_hlen_m1),
  .cfg_vstart(cfg_vstart), .ent_idx(ent_idx), .cur_cnt(cur_cnt)
);

// File: tb/fmt_line_combiner_tb.sv
module fmt_line_combiner_tb;
  localparam int AW = 13;
  localparam int NPTR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_en, cfg_combine;
  logic [1:0]  cfg_lines_m1;
  logic [12:0] cfg_hstart, cfg_hlen_m1, cfg_vstart;
  logic [14:0] cfg_vlen_m1;
  logic [3:0]  cfg_step_m1;
  logic [77:0] cfg_ptr_init;
  logic [5:0]  cfg_ent_cnt_m1;
  logic [11:0] cfg_ent_valid, cfg_ent_upd;
  logic [35:0] cfg_ent_sel;
  logic        hs_in = 0, vs_in = 0, in_valid = 0, wr_ready = 1;
  logic [11:0] in_data = '0;
  logic        in_ready, wr_valid, hs_out;
  logic [12:0] wr_addr;
  logic [11:0] wr_data;

  fmt_line_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_combine(cfg_combine),
    .cfg_lines_m1(cfg_lines_m1), .cfg_hstart(cfg_hstart), .cfg_hlen_m1(cfg_hlen_m1),
    .cfg_vstart(cfg_vstart), .cfg_vlen_m1(cfg_vlen_m1), .cfg_step_m1(cfg_step_m1),
    .cfg_ptr_init(cfg_ptr_init), .cfg_ent_cnt_m1(cfg_ent_cnt_m1),
    .cfg_ent_valid(cfg_ent_valid), .cfg_ent_sel(cfg_ent_sel), .cfg_ent_upd(cfg_ent_upd),
    .hs_in(hs_in), .vs_in(vs_in), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .hs_out(hs_out)
  );

  typedef struct packed {
    logic [1:0]  lines_m1;
    logic [12:0] hstart;
    logic [12:0] hlen_m1;
    logic [12:0] vstart;
    logic [14:0] vlen_m1;
    logic [3:0]  step_m1;
    logic [7:0]  nlines;
    logic [7:0]  exp_hs;
  } row_t;

  localparam row_t ROWS [3] = '{
    '{2'd2, 13'd20, 13'd767, 13'd16, 15'd5, 4'd5, 8'd24, 8'd2},
    '{2'd1, 13'd2,  13'd9,   13'd1,  15'd4, 4'd3, 8'd8,  8'd3},
    '{2'd0, 13'd0,  13'd5,   13'd0,  15'd2, 4'd0, 8'd4,  8'd3}
  };

  int n_chk = 0, n_fail = 0;
  int hs_seen = 0;
  int frame_err = 0;
  int hits [8192];

  // reference model state, derived from the requirements
  int m_ptr [NPTR];
  int m_v, m_grp;
  bit m_seen, m_first;
  int m_hs;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (hs_out) hs_seen++;

  function automatic bit merging();
    return cfg_en && cfg_combine;
  endfunction

  function automatic bit v_in(input int v);
    return v >= int'(cfg_vstart) && v <= int'(cfg_vstart) + int'(cfg_vlen_m1);
  endfunction

  task automatic load_example_prog();
    for (int k = 0; k < NPTR; k++) cfg_ptr_init[k*13 +: 13] = 13'(k);
    cfg_ent_cnt_m1 = {2'd1, 2'd1, 2'd1};
    cfg_ent_valid  = 12'b0011_0011_0011;
    cfg_ent_upd    = 12'b0011_0011_0011;
    cfg_ent_sel    = '0;
    for (int g = 0; g < 3; g++) begin
      cfg_ent_sel[(g*4+0)*3 +: 3] = 3'(4 - 2*g);
      cfg_ent_sel[(g*4+1)*3 +: 3] = 3'(5 - 2*g);
    end
  endtask

  task automatic do_vsync();
    @(negedge clk); in_valid = 0; vs_in = 1;
    @(negedge clk); vs_in = 0;
    m_seen = 0; m_first = 1; m_grp = 0; m_v = 0;
  endtask

  task automatic do_hsync();
    int nv;
    @(negedge clk); in_valid = 0; hs_in = 1;
    @(negedge clk); hs_in = 0;
    nv = m_seen ? m_v + 1 : 0;
    m_seen = 1;
    m_v = nv;
    if (!merging()) m_hs++;
    else if (v_in(nv)) begin
      if (m_first || m_grp == int'(cfg_lines_m1)) begin
        m_grp = 0; m_first = 0; m_hs++;
        for (int k = 0; k < NPTR; k++) m_ptr[k] = int'(cfg_ptr_init[k*13 +: 13]);
      end else m_grp++;
    end
  endtask

  task automatic px(input int j, input int line, input bit stall);
    bit ev; int ea, set, e, fl, sel;
    @(negedge clk);
    in_valid = 1; in_data = 12'(j * 7 + line);
    ev = 1; ea = j; sel = 0; fl = 0;
    if (merging()) begin
      set = (m_grp > 2) ? 2 : m_grp;
      if (m_seen && v_in(m_v) && j >= int'(cfg_hstart) && j - int'(cfg_hstart) <= int'(cfg_hlen_m1)) begin
        e  = (j - int'(cfg_hstart)) % (int'(cfg_ent_cnt_m1[set*2 +: 2]) + 1);
        fl = set*4 + e;
        sel = int'(cfg_ent_sel[fl*3 +: 3]);
        ev = cfg_ent_valid[fl];
        ea = m_ptr[sel];
      end else ev = 0;
    end
    #1;
    if (wr_valid !== ev || (ev && (int'(wr_addr) != ea || wr_data !== in_data))) begin
      frame_err++;
      if (frame_err < 4)
        $display("FAIL R5/R6 pixel %0d line %0d addr actual=%0d expected=%0d valid actual=%0b expected=%0b",
                 j, line, wr_addr, ea, wr_valid, ev);
    end
    if (wr_valid) hits[int'(wr_addr)]++;
    if (stall) begin
      wr_ready = 0;
      #1 check(in_ready == 0, "R9 in_ready follows wr_ready", int'(in_ready), 0);
      repeat (3) @(negedge clk);
      #1 check(wr_valid === ev && (!ev || int'(wr_addr) == ea), "R9 held pixel unchanged",
               int'(wr_addr), ea);
      wr_ready = 1;
    end
    if (merging() && ev && cfg_ent_upd[fl]) m_ptr[sel] = (m_ptr[sel] + int'(cfg_step_m1) + 1) % 8192;
  endtask

  task automatic run_frame(input int nlines, input int bp_line, input string tag);
    int len;
    frame_err = 0; m_hs = 0;
    for (int a = 0; a < 8192; a++) hits[a] = 0;
    do_vsync();
    hs_seen = 0;
    for (int l = 0; l < nlines; l++) begin
      do_hsync();
      len = (merging() && v_in(m_v)) ? int'(cfg_hstart) + int'(cfg_hlen_m1) + 4 : 6;
      for (int j = 0; j < len; j++) px(j, l, (l == bp_line) && (j == int'(cfg_hstart) + 1));
    end
    @(negedge clk); in_valid = 0;
    repeat (2) @(negedge clk);
    check(frame_err == 0, tag, frame_err, 0);
    check(hs_seen == m_hs, "R2 hs_out count vs model", hs_seen, m_hs);
  endtask

  task automatic apply_row(input row_t r);
    cfg_lines_m1 = r.lines_m1; cfg_hstart = r.hstart; cfg_hlen_m1 = r.hlen_m1;
    cfg_vstart = r.vstart; cfg_vlen_m1 = r.vlen_m1; cfg_step_m1 = r.step_m1;
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int bad;
    cfg_en = 1; cfg_combine = 1;
    load_example_prog();
    apply_row(ROWS[0]);
    repeat (3) @(negedge clk);
    // R10 reset state
    check(wr_valid == 0 && hs_out == 0, "R10 during reset", int'(wr_valid) + int'(hs_out), 0);
    rst_n = 1;
    @(negedge clk); #1;
    check(wr_valid == 0 && hs_out == 0, "R10 after reset", int'(wr_valid) + int'(hs_out), 0);

    // table of configurations: R2 R3 R4 R5 R6
    for (int r = 0; r < 3; r++) begin
      apply_row(ROWS[r]);
      run_frame(int'(ROWS[r].nlines), -1, "R3 R4 R5 R6 table frame");
      check(hs_seen == int'(ROWS[r].exp_hs), "R2 hs_out per group", hs_seen, int'(ROWS[r].exp_hs));
      if (r == 0) begin
        bad = 0;
        for (int a = 0; a < 8192; a++)
          if (hits[a] != ((a < 2304) ? 2 : 0)) bad++;
        check(bad == 0, "R5 interleave covers 0..2303 once per group", bad, 0);
      end
    end

    // R1 pass-through, merge bit clear
    apply_row(ROWS[1]);
    cfg_combine = 0;
    run_frame(3, -1, "R1 pass-through combine=0");
    check(hs_seen == 3, "R1 hs_out per hs_in", hs_seen, 3);
    // R1 pass-through, enable clear
    cfg_combine = 1; cfg_en = 0;
    run_frame(2, -1, "R1 pass-through enable=0");
    check(hs_seen == 2, "R1 hs_out per hs_in enable=0", hs_seen, 2);
    cfg_en = 1;

    // R7 invalid entry: set 0 entry 1 not written
    cfg_ent_valid[1] = 1'b0;
    run_frame(8, -1, "R7 cleared valid flag");
    cfg_ent_valid[1] = 1'b1;

    // R8 update bit clear on set 1 entry 0
    cfg_ent_upd[4] = 1'b0;
    run_frame(8, -1, "R8 cleared update bit");
    cfg_ent_upd[4] = 1'b1;

    // R6 three-entry set 0
    cfg_ent_cnt_m1[1:0] = 2'd2;
    cfg_ent_valid[2] = 1'b1; cfg_ent_upd[2] = 1'b1;
    cfg_ent_sel[2*3 +: 3] = 3'd3;
    run_frame(8, -1, "R6 three-entry set");
    load_example_prog();

    // R9 back-pressure inside a valid line
    run_frame(8, 2, "R9 back-pressure frame");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule